// File: doc/BRIEF.md
# Clock-Enable Control Register Slave

This block is a two-wire serial bus slave that holds a small bank of 8-bit control registers for a clock generator. Every register bit drives one enable line, so a system controller can switch individual clock outputs on or off over the bus. The bus pins arrive as a plain SCL input and an open-drain SDA line. The slave never drives SDA high. It pulls the line low only through `sda_oe`, and the pad or board pull-up supplies the high level.

A write opens with the write address byte. Two bytes follow that the slave acknowledges and throws away, a command byte and a count byte. Every byte after those is stored, starting at register 0 and moving up one register per byte, until STOP. A read opens with the read address byte, and the slave returns register 0, 1, 2 and so on straight away, with no command phase. Each new START, including a repeated START, brings the byte phase back to the address byte and the register index back to 0. The registers load their reset value only on reset, and bus traffic never reloads them.

Top module: `clkctl_i2c_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) and a STOP (SDA rising while SCL is high) are recognised in any state. The slave changes its own SDA drive only while SCL is low.
- R2: The address byte 1101_0010 (write) or 1101_0011 (read), sent MSB first with the direction flag in bit 0, is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the slave ignores the rest of the transfer until the next START.
- R3: On a write, the two bytes after the address are each acknowledged and then discarded. A write that stops after them leaves every register unchanged.
- R4: Each data byte of a write is received MSB first, acknowledged, and stored in registers 0, 1, 2 and so on in order. Each stored byte changes only its own register.
- R5: The register index restarts at 0 on every transfer.
- R6: On a read, the slave sends register 0, then 1, 2 and so on, MSB first, starting in the clock after the address acknowledge. It releases SDA during the master's acknowledge slot.
- R7: If the master does not acknowledge a read byte, the slave stops driving SDA until the next START or STOP.
- R8: Data bytes written beyond the last register are acknowledged and dropped. Bytes read beyond the last register are 0xFF.
- R9: Reset loads RESET_BYTE into every register, and bus traffic never reloads it. Output `out_en[8*j+k]` is bit k of register j.
- R10: A repeated START in the middle of a transfer returns the slave to the address phase, so a repeated START followed by a read address returns register 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1; otherwise the line is released |
| out_en | output | NUM_REGS*8 | Clock-output enables, one bit per register bit |

## Verification
The bench goes after the don't-care bytes, the index restart and the end of the register bank. It checks that a design which stored the command byte would show it in register 0, that one which kept the index across transfers would fill register 1 on the second write, and that one which wrapped past the last register would overwrite register 0 or return stale data instead of 0xFF. It also covers a wrong address: a slave that acknowledged it, or that woke up on the next byte, would change registers or pull SDA low. Two more cases are a master NACK, after which a slave that kept driving would corrupt the idle clocks that follow, and a repeated START, after which a slave stuck in the data phase would store the address byte as data.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RX_ACK,
    S_TX,
    S_TX_ACK
  } bus_state_e;

  typedef enum logic [1:0] {
    P_ADDR,
    P_CMD,
    P_CNT,
    P_DATA
  } byte_phase_e;
endpackage

// File: rtl/clkctl_bus_sync.sv
module clkctl_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // stage SYNC_STAGES-1 is the synchronised value, stage SYNC_STAGES its last-cycle copy
  logic [SYNC_STAGES:0] scl_p, sda_p;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
      sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_s     = scl_p[SYNC_STAGES-1];
  assign scl_q     = scl_p[SYNC_STAGES];
  assign sda_s     = sda_p[SYNC_STAGES-1];
  assign sda_q     = sda_p[SYNC_STAGES];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/clkctl_byte_engine.sv
module clkctl_byte_engine
  import clkctl_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'b1101001,
  parameter int         PTR_W    = $clog2(NUM_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             reg_we,
  output logic [PTR_W-1:0] reg_ptr,
  output logic [7:0]       wr_data
);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

  bus_state_e  state;
  byte_phase_e phase;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg;
  logic        is_read, mst_ack;
  logic        byte_done, addr_hit;
  logic [PTR_W-1:0] ptr_inc;

  assign byte_done = (state == S_RX) && scl_fall && (bit_cnt == 4'd8);
  assign addr_hit  = (shreg[7:1] == DEV_ADDR);
  assign ptr_inc   = (reg_ptr == PTR_END) ? reg_ptr : reg_ptr + 1'b1;
  assign reg_we    = byte_done && (phase == P_DATA) && (reg_ptr != PTR_END)
                     && !start_det && !stop_det;
  assign wr_data   = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      phase   <= P_ADDR;
      bit_cnt <= '0;
      shreg   <= '0;
      is_read <= 1'b0;
      mst_ack <= 1'b0;
      sda_oe  <= 1'b0;
      reg_ptr <= '0;
    end else if (start_det) begin
      state   <= S_RX;
      phase   <= P_ADDR;
      bit_cnt <= '0;
      reg_ptr <= '0;
      is_read <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state   <= S_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        S_RX: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            unique case (phase)
              P_ADDR: begin
                if (addr_hit) begin
                  sda_oe  <= 1'b1;
                  is_read <= shreg[0];
                  phase   <= P_CMD;
                  state   <= S_RX_ACK;
                end else begin
                  state   <= S_IDLE;
                end
              end
              P_CMD: begin
                sda_oe <= 1'b1;
                phase  <= P_CNT;
                state  <= S_RX_ACK;
              end
              P_CNT: begin
                sda_oe <= 1'b1;
                phase  <= P_DATA;
                state  <= S_RX_ACK;
              end
              default: begin
                sda_oe  <= 1'b1;
                reg_ptr <= ptr_inc;
                state   <= S_RX_ACK;
              end
            endcase
          end
        end
        S_RX_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (is_read) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe  <= 1'b0;
              reg_ptr <= ptr_inc;
              state   <= S_TX_ACK;
            end else begin
              bit_cnt <= bit_cnt + 4'd1;
              shreg   <= {shreg[6:0], 1'b0};
              sda_oe  <= ~shreg[6];
            end
          end
        end
        S_TX_ACK: begin
          if (scl_rise) begin
            mst_ack <= ~sda_s;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            if (mst_ack) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= S_TX;
            end else begin
              state  <= S_IDLE;
            end
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile #(
  parameter int         NUM_REGS   = 8,
  parameter int         PTR_W      = $clog2(NUM_REGS + 1),
  parameter logic [7:0] RESET_BYTE = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [PTR_W-1:0]      ptr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] out_en
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

  logic [7:0] regs [NUM_REGS];
  logic       in_range;

  assign in_range = (ptr < PTR_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= RESET_BYTE;
    end else if (we && in_range) begin
      regs[ptr[IDX_W-1:0]] <= wdata;
    end
  end

  assign rd_data = in_range ? regs[ptr[IDX_W-1:0]] : 8'hFF;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign out_en[g*8 +: 8] = regs[g];
  end
endmodule

// File: rtl/clkctl_i2c_slave.sv
module clkctl_i2c_slave #(
  parameter int         NUM_REGS    = 8,
  parameter logic [6:0] DEV_ADDR    = 7'b1101001,
  parameter logic [7:0] RESET_BYTE  = 8'hFF,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] out_en
);
  localparam int PTR_W = $clog2(NUM_REGS + 1);

  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             reg_we;
  logic [PTR_W-1:0] reg_ptr;
  logic [7:0]       wr_data, rd_data;

  clkctl_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  clkctl_byte_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_ptr(reg_ptr), .wr_data(wr_data)
  );

  clkctl_regfile #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .RESET_BYTE(RESET_BYTE)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .ptr(reg_ptr), .wdata(wr_data),
    .rd_data(rd_data), .out_en(out_en)
  );
endmodule

// File: rtl/clkctl_i2c_checker.sv
module clkctl_i2c_checker #(
  parameter int         NUM_REGS   = 8,
  parameter int         PTR_W      = 4,
  parameter logic [7:0] RESET_BYTE = 8'hFF
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] out_en,
  input logic                  reg_we,
  input logic [PTR_W-1:0]      reg_ptr
);
  logic [NUM_REGS*8-1:0] prev_en;
  logic [NUM_REGS-1:0]   chg;

  always_ff @(posedge clk) begin
    if (rst) prev_en <= {NUM_REGS{RESET_BYTE}};
    else     prev_en <= out_en;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
    assign chg[g] = (prev_en[g*8 +: 8] != out_en[g*8 +: 8]);
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i); // R1
  AST_ONE_BYTE_PER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (chg != '0) |-> ($past(reg_we) && $countones(chg) == 1)); // R4
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> sda_oe); // R4
  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (reg_ptr < PTR_W'(NUM_REGS))); // R8
  AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_en == {NUM_REGS{RESET_BYTE}})); // R9
endmodule

bind clkctl_i2c_slave clkctl_i2c_checker #(
  .NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .RESET_BYTE(RESET_BYTE)
) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .out_en(out_en), .reg_we(reg_we), .reg_ptr(reg_ptr)
);

// File: tb/tb_clkctl_i2c_slave.sv
`timescale 1ns/1ps
module tb_clkctl_i2c_slave;
  localparam int         NREG = 8;
  localparam logic [7:0] DEF  = 8'hFF;
  localparam int         Q    = 8;
  localparam int         H    = 16;

  logic clk = 1'b0, rst = 1'b1, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_line;
  logic [NREG*8-1:0] out_en;
  logic [7:0] mdl [NREG];
  logic [7:0] wbuf [16];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  assign sda_line = m_sda & ~sda_oe;
  always #2.5 clk = ~clk;

  clkctl_i2c_slave #(.NUM_REGS(NREG), .RESET_BYTE(DEF)) dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .out_en(out_en)
  );

  function automatic logic [NREG*8-1:0] flat_model();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = mdl[i];
    return f;
  endfunction

  function automatic logic [7:0] exp_read(int idx);
    return (idx < NREG) ? mdl[idx] : 8'hFF;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic bstart();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic wbit(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(Q);
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    b = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = !a;
  endtask

  task automatic rbyte(output logic [7:0] d, input bit mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(!mack);
  endtask

  // full write of n bytes from wbuf, acks checked, model updated
  task automatic write_txn(input int n, input logic [7:0] cmd, input logic [7:0] cnt);
    bit a;
    bstart();
    wbyte(8'hD2, a); chk(a, "R2", "write address ack", a, 1);
    wbyte(cmd, a);   chk(a, "R3", "command byte ack", a, 1);
    wbyte(cnt, a);   chk(a, "R3", "count byte ack", a, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], a);
      if (i < NREG) begin
        chk(a, "R4", "data byte ack", a, 1);
        mdl[i] = wbuf[i];
      end else begin
        chk(a, "R8", "ack beyond last register", a, 1);
      end
    end
    bstop();
    chk(out_en == flat_model(), "R4", "register contents after write", out_en, flat_model());
  endtask

  task automatic read_txn(input int n);
    bit a;
    logic [7:0] d;
    bstart();
    wbyte(8'hD3, a); chk(a, "R2", "read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(d, i < n - 1);
      if (i < NREG) chk(d == exp_read(i), "R6", "read byte in order", d, exp_read(i));
      else          chk(d == 8'hFF, "R8", "read beyond last register", d, 8'hFF);
    end
    bstop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    logic b;
    logic [NREG*8-1:0] snap;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NREG; i++) mdl[i] = DEF;
    tick(5); rst = 1'b0; tick(5);

    // R9 reset state
    chk(out_en == {NREG{DEF}}, "R9", "reset values", out_en, {NREG{DEF}});
    chk(sda_oe == 1'b0, "R1", "released after reset", sda_oe, 0);

    // R3 dummies only: no register change
    bstart();
    wbyte(8'hD2, a); chk(a, "R2", "write address ack", a, 1);
    wbyte(8'h00, a); chk(a, "R3", "command ack", a, 1);
    wbyte(8'h05, a); chk(a, "R3", "count ack", a, 1);
    bstop();
    chk(out_en == {NREG{DEF}}, "R3", "dummies not stored", out_en, {NREG{DEF}});

    // R4 ordered write, dummies distinct from data
    wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56;
    write_txn(3, 8'hA5, 8'h03);

    // R5 index restarts: single byte goes to register 0
    wbuf[0] = 8'h9C;
    write_txn(1, 8'h00, 8'h01);
    chk(out_en[15:8] == 8'h34, "R5", "register 1 untouched", out_en[15:8], 8'h34);

    // R2 wrong address ignored through the whole transfer
    snap = out_en;
    bstart();
    wbyte(8'hA4, a); chk(!a, "R2", "foreign address nack", a, 0);
    wbyte(8'h00, a); chk(!a, "R2", "ignored byte nack", a, 0);
    wbyte(8'h00, a);
    wbyte(8'h3C, a); chk(!a, "R2", "ignored data nack", a, 0);
    bstop();
    chk(out_en == snap, "R2", "registers after foreign address", out_en, snap);
    bstart();
    wbyte(8'hD1, a); chk(!a, "R2", "neighbour address nack", a, 0);
    bstop();

    // R8 write past the end, then read past the end
    for (int i = 0; i < NREG + 3; i++) wbuf[i] = 8'(i * 17 + 3);
    write_txn(NREG + 3, 8'h11, 8'h22);
    read_txn(NREG + 2);

    // R10 repeated start: write phase then read returns register 0
    bstart();
    wbyte(8'hD2, a); wbyte(8'h00, a);
    bstart();
    wbyte(8'hD3, a); chk(a, "R10", "address ack after repeated start", a, 1);
    rbyte(d, 1'b0);
    chk(d == mdl[0], "R10", "register 0 after repeated start", d, mdl[0]);
    bstop();

    // R10 repeated start mid-data: address byte not stored as data
    bstart();
    wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'h00, a); wbyte(8'h61, a);
    bstart();
    wbyte(8'hD2, a); chk(a, "R10", "address phase after repeated start", a, 1);
    wbyte(8'h00, a); wbyte(8'h00, a); wbyte(8'h7E, a);
    bstop();
    mdl[0] = 8'h7E;
    chk(out_en == flat_model(), "R10", "registers after repeated start", out_en, flat_model());

    // R7 master nack: slave silent on following clocks
    bstart();
    wbyte(8'hD3, a);
    rbyte(d, 1'b0);
    chk(d == mdl[0], "R6", "single read byte", d, mdl[0]);
    for (int i = 0; i < 9; i++) begin
      rbit(b);
      chk(b == 1'b1, "R7", "released after master nack", b, 1);
    end
    bstop();

    // random mix
    for (int it = 0; it < 8; it++) begin
      int n;
      n = 1 + int'($urandom_range(NREG + 1));
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_txn(n, 8'($urandom), 8'($urandom));
      read_txn(1 + int'($urandom_range(NREG)));
    end

    // R9 reset restores defaults, bus traffic did not
    chk(out_en == flat_model(), "R9", "no reload from bus", out_en, flat_model());
    rst = 1'b1; tick(3); rst = 1'b0; tick(2);
    for (int i = 0; i < NREG; i++) mdl[i] = DEF;
    chk(out_en == {NREG{DEF}}, "R9", "defaults after reset", out_en, {NREG{DEF}});
    read_txn(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule